// File: doc/BRIEF.md
# Rotor Cipher Sequencer

This block enciphers one letter at a time the way an electromechanical rotor cipher does. A letter code from 0 to 25 arrives with a start strobe. The engine swaps it through a plugboard table, then sends it forward through three or four rotors, off a reflector table, back through the same rotors in reverse order, and through the plugboard a second time. The result appears with a one-cycle done strobe. After every letter the rotors advance like an odometer, so the same input letter maps to a different output each time.

Every rotor pass takes two register stages. The first stage adds the rotor position to the letter modulo 26. The second stage looks the sum up in the rotor wiring and subtracts the position modulo 26. Because of this, the latency is fixed and depends only on how many rotors are in use. A single write port loads the plugboard, the reflector, each rotor's forward wiring and each rotor's starting position. The inverse wiring used on the return pass is kept up to date by the same writes.

Top module: `rotor_cipher_engine`

## Requirements
- R1: After reset, busy, done and letter_out are all 0. Every table holds the identity map and every rotor position is 0, so with no configuration written each letter enciphers to itself.
- R2: With four_rotor_mode low, three rotors are used. If start is accepted on clock edge 0, done is high during the cycle that follows edge 16, which is 17 cycles in all.
- R3: With four_rotor_mode high, four rotors are used and done follows edge 20, which is 21 cycles in all.
- R4: done is high for exactly one cycle. letter_out carries the result in that cycle and keeps its value until the next done.
- R5: busy goes high in the cycle after start is accepted and stays high until done rises, at which point busy falls. A start pulse seen while busy is high is ignored.
- R6: The result is P(B0(..B(n-1)(F(F(n-1)(..F0(P(x)))))), all arithmetic modulo 26. P is the plugboard and F is the reflector. Rotor r at position p maps x forward to W_r[(x+p) mod 26] − p mod 26. On the return pass rotor r maps x to W_r⁻¹[(x+p) mod 26] − p mod 26.
- R7: When done rises, rotor 0 advances by one. Any rotor that wraps from 25 to 0 advances the next rotor. Only the rotors in use for that letter take part, so in three-rotor mode rotor 3 never moves.
- R8: Configuration writes happen on cfg_we. cfg_sel selects the target: 0 is the plugboard entry cfg_addr, 1 is the reflector entry cfg_addr, 2 to 5 are forward wiring entry cfg_addr of rotor cfg_sel−2, and 6 sets the position of rotor cfg_addr to cfg_data. A write is ignored in any of these cases: busy is high, cfg_addr or cfg_data is above 25, the rotor index is not below 4, or cfg_sel is 7.
- R9: four_rotor_mode is sampled only when start is accepted. Changing it during a letter does not alter that letter's latency or result.
- R10: A start whose letter_in is above 25 is ignored: busy stays low and no done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to encipher letter_in |
| letter_in | input | 5 | Input letter code, 0 to 25 |
| four_rotor_mode | input | 1 | 1 selects four rotors, 0 selects three |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration target select |
| cfg_addr | input | 5 | Table entry, or rotor index when setting a position |
| cfg_data | input | 5 | Value to write |
| busy | output | 1 | A letter is being processed |
| done | output | 1 | One-cycle strobe marking a valid result |
| letter_out | output | 5 | Enciphered letter |

## Verification
The checker covers the timing on every cycle. It checks that done lasts one cycle and that busy falls only as done rises. It checks that busy rises only after a start. It checks that letter_out stays in range and changes only with done. It also counts cycles from the rise of busy to done and compares the count with the rotor mode captured at start. The substitution result, the odometer stepping with its carries, and the rules for ignored writes and ignored starts can only be seen through the scenarios. These compare each output letter with a reference cipher in the bench that tracks every accepted configuration write.

// File: rtl/rce_pkg.sv
package rce_pkg;

    localparam int unsigned ALPHA = 26;
    localparam int unsigned LW    = 5;

    typedef logic [LW-1:0] letter_t;

    localparam letter_t        ALPHA_L = LW'(ALPHA);
    localparam letter_t        TOP_L   = LW'(ALPHA - 1);
    localparam logic [LW:0]    ALPHA_X = (LW+1)'(ALPHA);

    typedef enum logic [2:0] {
        CFG_PLUG = 3'd0,
        CFG_REFL = 3'd1,
        CFG_ROT0 = 3'd2,
        CFG_ROT1 = 3'd3,
        CFG_ROT2 = 3'd4,
        CFG_ROT3 = 3'd5,
        CFG_POS  = 3'd6,
        CFG_NONE = 3'd7
    } cfg_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PLUG_IN,
        ST_FWD_ADD,
        ST_FWD_LUT,
        ST_REFL,
        ST_BWD_ADD,
        ST_BWD_LUT,
        ST_PLUG_OUT,
        ST_EMIT
    } seq_state_e;

    function automatic logic is_letter(letter_t a);
        return a < ALPHA_L;
    endfunction

    function automatic letter_t add26(letter_t a, letter_t b);
        logic [LW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= ALPHA_X) s = s - ALPHA_X;
        return s[LW-1:0];
    endfunction

    function automatic letter_t sub26(letter_t a, letter_t b);
        logic [LW:0] d;
        d = {1'b0, a} + ALPHA_X - {1'b0, b};
        if (d >= ALPHA_X) d = d - ALPHA_X;
        return d[LW-1:0];
    endfunction

endpackage

// File: rtl/rce_subst_table.sv
module rce_subst_table
    import rce_pkg::*;
#(
    parameter int unsigned DEPTH = ALPHA
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  letter_t waddr,
    input  letter_t wdata,
    input  letter_t raddr,
    output letter_t rdata
);

    letter_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= LW'(i);
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rce_rotor_bank.sv
module rce_rotor_bank
    import rce_pkg::*;
#(
    parameter  int unsigned ROTORS = 4,
    localparam int unsigned IW     = (ROTORS > 1) ? $clog2(ROTORS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wire_we,
    input  logic [IW-1:0] wire_rotor,
    input  letter_t       wire_addr,
    input  letter_t       wire_data,
    input  logic          pos_we,
    input  logic [IW-1:0] pos_rotor,
    input  letter_t       pos_data,
    input  logic          step,
    input  logic [IW-1:0] step_last,
    input  logic [IW-1:0] sel_rotor,
    input  logic          sel_inverse,
    input  letter_t       lut_addr,
    output letter_t       lut_data,
    output letter_t       sel_pos
);

    letter_t           pos_all [ROTORS];
    letter_t           fwd_rd  [ROTORS];
    letter_t           inv_rd  [ROTORS];
    logic [ROTORS-1:0] adv;

    // odometer carry: a rotor advances when every rotor below it wraps
    always_comb begin
        adv    = '0;
        adv[0] = step;
        for (int r = 1; r < ROTORS; r++) begin
            adv[r] = adv[r-1] && (pos_all[r-1] == TOP_L) && (IW'(r) <= step_last);
        end
    end

    for (genvar r = 0; r < ROTORS; r++) begin : g_rotor
        letter_t fwd_q [ALPHA];
        letter_t inv_q [ALPHA];
        letter_t pos_q;
        logic    wire_hit;
        logic    pos_hit;

        assign wire_hit = wire_we && (wire_rotor == IW'(r));
        assign pos_hit  = pos_we  && (pos_rotor  == IW'(r));

        // a forward entry write also records the matching inverse entry
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < ALPHA; i++) begin
                    fwd_q[i] <= LW'(i);
                    inv_q[i] <= LW'(i);
                end
            end else if (wire_hit) begin
                fwd_q[wire_addr] <= wire_data;
                inv_q[wire_data] <= wire_addr;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)          pos_q <= '0;
            else if (pos_hit) pos_q <= pos_data;
            else if (adv[r])  pos_q <= add26(pos_q, LW'(1));
        end

        assign pos_all[r] = pos_q;
        assign fwd_rd[r]  = fwd_q[lut_addr];
        assign inv_rd[r]  = inv_q[lut_addr];
    end

    assign lut_data = sel_inverse ? inv_rd[sel_rotor] : fwd_rd[sel_rotor];
    assign sel_pos  = pos_all[sel_rotor];

endmodule

// File: rtl/rce_sequencer.sv
module rce_sequencer
    import rce_pkg::*;
#(
    parameter  int unsigned ROTORS = 4,
    localparam int unsigned IW     = (ROTORS > 1) ? $clog2(ROTORS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  letter_t       letter_in,
    input  logic          wide_mode,
    output letter_t       tbl_addr,
    input  letter_t       plug_data,
    input  letter_t       refl_data,
    input  letter_t       rotor_data,
    input  letter_t       rotor_pos,
    output logic [IW-1:0] rotor_idx,
    output logic          rotor_inv,
    output logic          step,
    output logic [IW-1:0] step_last,
    output logic          busy,
    output logic          done,
    output letter_t       letter_out
);

    seq_state_e    state_q;
    letter_t       x_q;
    letter_t       out_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_idx;
    logic          wide_q;
    logic          done_q;

    assign last_idx = wide_q ? IW'(ROTORS - 1) : IW'(ROTORS - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            x_q     <= '0;
            out_q   <= '0;
            idx_q   <= '0;
            wide_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && is_letter(letter_in)) begin
                        x_q     <= letter_in;
                        wide_q  <= wide_mode;
                        state_q <= ST_PLUG_IN;
                    end
                end
                ST_PLUG_IN: begin
                    x_q     <= plug_data;
                    idx_q   <= '0;
                    state_q <= ST_FWD_ADD;
                end
                ST_FWD_ADD: begin
                    x_q     <= add26(x_q, rotor_pos);
                    state_q <= ST_FWD_LUT;
                end
                ST_FWD_LUT: begin
                    x_q <= sub26(rotor_data, rotor_pos);
                    if (idx_q == last_idx) begin
                        state_q <= ST_REFL;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_FWD_ADD;
                    end
                end
                ST_REFL: begin
                    x_q     <= refl_data;
                    state_q <= ST_BWD_ADD;
                end
                ST_BWD_ADD: begin
                    x_q     <= add26(x_q, rotor_pos);
                    state_q <= ST_BWD_LUT;
                end
                ST_BWD_LUT: begin
                    x_q <= sub26(rotor_data, rotor_pos);
                    if (idx_q == '0) begin
                        state_q <= ST_PLUG_OUT;
                    end else begin
                        idx_q   <= idx_q - 1'b1;
                        state_q <= ST_BWD_ADD;
                    end
                end
                ST_PLUG_OUT: begin
                    x_q     <= plug_data;
                    state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    out_q   <= x_q;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tbl_addr   = x_q;
    assign rotor_idx  = idx_q;
    assign rotor_inv  = (state_q == ST_BWD_ADD) || (state_q == ST_BWD_LUT);
    assign step       = (state_q == ST_EMIT);
    assign step_last  = last_idx;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign letter_out = out_q;

endmodule

// File: rtl/rotor_cipher_engine.sv
module rotor_cipher_engine
    import rce_pkg::*;
#(
    parameter int unsigned ROTORS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] letter_in,
    input  logic          four_rotor_mode,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [LW-1:0] cfg_addr,
    input  logic [LW-1:0] cfg_data,
    output logic          busy,
    output logic          done,
    output logic [LW-1:0] letter_out
);

    localparam int unsigned IW = (ROTORS > 1) ? $clog2(ROTORS) : 1;

    logic          cfg_ok;
    logic          plug_we;
    logic          refl_we;
    logic          wire_we;
    logic          pos_we;
    logic [2:0]    rot_off;
    letter_t       tbl_addr;
    letter_t       plug_data;
    letter_t       refl_data;
    letter_t       rotor_data;
    letter_t       rotor_pos;
    logic [IW-1:0] rotor_idx;
    logic          rotor_inv;
    logic          step;
    logic [IW-1:0] step_last;

    // configuration decode: writes only while idle and in range
    assign cfg_ok  = cfg_we && !busy && is_letter(cfg_addr) && is_letter(cfg_data);
    assign rot_off = cfg_sel - 3'(CFG_ROT0);
    assign plug_we = cfg_ok && (cfg_sel == 3'(CFG_PLUG));
    assign refl_we = cfg_ok && (cfg_sel == 3'(CFG_REFL));
    assign wire_we = cfg_ok && (cfg_sel >= 3'(CFG_ROT0)) && (cfg_sel <= 3'(CFG_ROT3))
                     && (int'(rot_off) < int'(ROTORS));
    assign pos_we  = cfg_ok && (cfg_sel == 3'(CFG_POS)) && (int'(cfg_addr) < int'(ROTORS));

    rce_subst_table #(.DEPTH(ALPHA)) u_plug (
        .clk   (clk),
        .rst   (rst),
        .we    (plug_we),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (tbl_addr),
        .rdata (plug_data)
    );

    rce_subst_table #(.DEPTH(ALPHA)) u_refl (
        .clk   (clk),
        .rst   (rst),
        .we    (refl_we),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (tbl_addr),
        .rdata (refl_data)
    );

    rce_rotor_bank #(.ROTORS(ROTORS)) u_rotors (
        .clk         (clk),
        .rst         (rst),
        .wire_we     (wire_we),
        .wire_rotor  (rot_off[IW-1:0]),
        .wire_addr   (cfg_addr),
        .wire_data   (cfg_data),
        .pos_we      (pos_we),
        .pos_rotor   (cfg_addr[IW-1:0]),
        .pos_data    (cfg_data),
        .step        (step),
        .step_last   (step_last),
        .sel_rotor   (rotor_idx),
        .sel_inverse (rotor_inv),
        .lut_addr    (tbl_addr),
        .lut_data    (rotor_data),
        .sel_pos     (rotor_pos)
    );

    rce_sequencer #(.ROTORS(ROTORS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .letter_in  (letter_in),
        .wide_mode  (four_rotor_mode),
        .tbl_addr   (tbl_addr),
        .plug_data  (plug_data),
        .refl_data  (refl_data),
        .rotor_data (rotor_data),
        .rotor_pos  (rotor_pos),
        .rotor_idx  (rotor_idx),
        .rotor_inv  (rotor_inv),
        .step       (step),
        .step_last  (step_last),
        .busy       (busy),
        .done       (done),
        .letter_out (letter_out)
    );

endmodule

// File: rtl/rce_checker.sv
module rce_checker
    import rce_pkg::*;
#(
    parameter int unsigned ROTORS = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          four_rotor_mode,
    input logic          busy,
    input logic          done,
    input logic [LW-1:0] letter_out
);

    localparam logic [7:0] NARROW_CNT = 8'(4 * (ROTORS - 1) + 4);
    localparam logic [7:0] WIDE_CNT   = 8'(4 * ROTORS + 4);

    logic [7:0] busy_cnt;
    logic       busy_d;
    logic       mode_d;
    logic       mode_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt  <= '0;
            busy_d    <= 1'b0;
            mode_d    <= 1'b0;
            mode_seen <= 1'b0;
        end else begin
            busy_d   <= busy;
            mode_d   <= four_rotor_mode;
            busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
            if (busy && !busy_d) mode_seen <= mode_d;
        end
    end

    assert_latency_narrow_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_seen) |-> (busy_cnt == NARROW_CNT));

    assert_latency_wide_R3: assert property (@(posedge clk) disable iff (rst)
        (done && mode_seen) |-> (busy_cnt == WIDE_CNT));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(letter_out));

    assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_busy_begin_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_out_range_R6: assert property (@(posedge clk) disable iff (rst)
        letter_out < ALPHA_L);

endmodule

bind rotor_cipher_engine rce_checker #(.ROTORS(ROTORS)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .four_rotor_mode (four_rotor_mode),
    .busy            (busy),
    .done            (done),
    .letter_out      (letter_out)
);

// File: tb/rotor_cipher_engine_tb.sv
`timescale 1ns/1ps
module rotor_cipher_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [4:0] letter_in = '0;
    logic       four_rotor_mode = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [4:0] cfg_addr = '0;
    logic [4:0] cfg_data = '0;
    logic       busy;
    logic       done;
    logic [4:0] letter_out;

    int checks = 0;
    int errors = 0;

    int mplug [26];
    int mrefl [26];
    int mfwd  [4][26];
    int mpos  [4];

    always #10 clk = ~clk;

    rotor_cipher_engine #(.ROTORS(4)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .letter_in       (letter_in),
        .four_rotor_mode (four_rotor_mode),
        .cfg_we          (cfg_we),
        .cfg_sel         (cfg_sel),
        .cfg_addr        (cfg_addr),
        .cfg_data        (cfg_data),
        .busy            (busy),
        .done            (done),
        .letter_out      (letter_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 26; i++) begin
            mplug[i] = i;
            mrefl[i] = i;
            for (int r = 0; r < 4; r++) mfwd[r][i] = i;
        end
        for (int r = 0; r < 4; r++) mpos[r] = 0;
    endfunction

    function automatic int model_inv(int r, int y);
        for (int j = 0; j < 26; j++) if (mfwd[r][j] == y) return j;
        return 0;
    endfunction

    function automatic int model_cipher(int l, bit wide);
        int x;
        int last;
        last = wide ? 3 : 2;
        x = mplug[l];
        for (int r = 0; r <= last; r++) begin
            x = (x + mpos[r]) % 26;
            x = (mfwd[r][x] - mpos[r] + 26) % 26;
        end
        x = mrefl[x];
        for (int r = last; r >= 0; r--) begin
            x = (x + mpos[r]) % 26;
            x = (model_inv(r, x) - mpos[r] + 26) % 26;
        end
        return mplug[x];
    endfunction

    function automatic void model_step(bit wide);
        int last;
        last = wide ? 3 : 2;
        for (int r = 0; r <= last; r++) begin
            if (mpos[r] == 25) mpos[r] = 0;
            else begin
                mpos[r] = mpos[r] + 1;
                break;
            end
        end
    endfunction

    // idle-time configuration write, mirrored into the model when legal
    task automatic cfg_write(input int sel, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_addr = 5'(addr); cfg_data = 5'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 26 && data < 26) begin
            if (sel == 0) mplug[addr] = data;
            else if (sel == 1) mrefl[addr] = data;
            else if (sel >= 2 && sel <= 5) mfwd[sel-2][addr] = data;
            else if (sel == 6 && addr < 4) mpos[addr] = data;
        end
    endtask

    // one letter; optional disturbances during the busy window
    task automatic encipher(input int l, input bit wide, input bit flip_mode,
                            input bit poke_start, input bit poke_cfg, input string req);
        int cycles;
        int exp;
        bit busy_ok;
        int held;
        exp = model_cipher(l, wide);
        @(negedge clk);
        start = 1'b1; letter_in = 5'(l); four_rotor_mode = wide;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 busy after start", int'(busy), 1);
        cycles  = 0;
        busy_ok = 1'b1;
        do begin
            if (flip_mode) four_rotor_mode = !wide;
            if (poke_start && cycles == 3) begin
                start = 1'b1; letter_in = 5'((l + 5) % 26);
            end else start = 1'b0;
            if (poke_cfg && cycles == 4) begin
                cfg_we = 1'b1; cfg_sel = 3'd6; cfg_addr = 5'd0; cfg_data = 5'd9;
            end else cfg_we = 1'b0;
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (!done && !busy) busy_ok = 1'b0;
        end while (!done && cycles < 40);
        start = 1'b0; cfg_we = 1'b0;
        check(busy_ok, "R5 busy held until done", int'(busy_ok), 1);
        check(cycles == (wide ? 20 : 16), {req, " latency edges"}, cycles, wide ? 20 : 16);
        check(busy == 1'b0, "R5 busy low with done", int'(busy), 0);
        check(int'(letter_out) == exp, {req, " letter"}, int'(letter_out), exp);
        model_step(wide);
        held = int'(letter_out);
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", int'(done), 0);
        check(int'(letter_out) == held, "R4 letter_out held", int'(letter_out), held);
        check(busy == 1'b0, "R5 no restart from ignored start", int'(busy), 0);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(letter_out == 5'd0, "R1 reset letter_out", int'(letter_out), 0);
    endtask

    task automatic t_identity();
        encipher(0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 identity");
        encipher(13, 1'b0, 1'b0, 1'b0, 1'b0, "R1 identity");
        encipher(25, 1'b1, 1'b0, 1'b0, 1'b0, "R1 identity");
    endtask

    task automatic t_load_tables();
        cfg_write(0, 0, 7);  cfg_write(0, 7, 0);
        cfg_write(0, 3, 19); cfg_write(0, 19, 3);
        for (int i = 0; i < 26; i++) cfg_write(1, i, 25 - i);
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 26; i++) cfg_write(2 + r, i, (i * (3 + 2 * r) + 5 * r + 1) % 26);
        cfg_write(6, 0, 4); cfg_write(6, 1, 11); cfg_write(6, 2, 20); cfg_write(6, 3, 2);
        for (int k = 0; k < 4; k++) encipher(0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 R2 repeated letter");
        encipher(7, 1'b0, 1'b0, 1'b0, 1'b0, "R6 plugged letter");
        encipher(19, 1'b0, 1'b0, 1'b0, 1'b0, "R6 plugged letter");
    endtask

    task automatic t_four_rotor();
        encipher(12, 1'b1, 1'b0, 1'b0, 1'b0, "R3 four rotors");
        encipher(2, 1'b1, 1'b1, 1'b0, 1'b0, "R9 mode flipped while busy");
        encipher(9, 1'b0, 1'b1, 1'b0, 1'b0, "R9 mode flipped while busy");
    endtask

    task automatic t_busy_start();
        encipher(4, 1'b0, 1'b0, 1'b1, 1'b0, "R5 start while busy");
        repeat (25) begin
            @(negedge clk);
            if (done) break;
        end
        check(done == 1'b0, "R5 no done from ignored start", int'(done), 0);
        encipher(4, 1'b0, 1'b0, 1'b0, 1'b0, "R5 follow-up letter");
    endtask

    task automatic t_bad_letter();
        bit saw_done;
        @(negedge clk);
        start = 1'b1; letter_in = 5'd27;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10 invalid letter not accepted", int'(busy), 0);
        saw_done = 1'b0;
        repeat (24) begin
            @(negedge clk);
            if (done) saw_done = 1'b1;
        end
        check(!saw_done, "R10 no done for invalid letter", int'(saw_done), 0);
        encipher(21, 1'b0, 1'b0, 1'b0, 1'b0, "R10 next valid letter");
    endtask

    task automatic t_cfg_rules();
        encipher(5, 1'b0, 1'b0, 1'b0, 1'b1, "R8 write while busy");
        encipher(5, 1'b0, 1'b0, 1'b0, 1'b0, "R8 busy write ignored");
        cfg_write(0, 1, 26);
        cfg_write(0, 30, 2);
        cfg_write(6, 5, 3);
        cfg_write(7, 1, 1);
        cfg_write(1, 28, 0);
        encipher(1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 invalid writes ignored");
        encipher(30 % 26, 1'b0, 1'b0, 1'b0, 1'b0, "R8 invalid writes ignored");
    endtask

    task automatic t_carry();
        cfg_write(6, 0, 25); cfg_write(6, 1, 25); cfg_write(6, 2, 25); cfg_write(6, 3, 17);
        encipher(3, 1'b0, 1'b0, 1'b0, 1'b0, "R7 triple wrap three rotors");
        encipher(3, 1'b1, 1'b0, 1'b0, 1'b0, "R7 rotor 3 untouched");
        cfg_write(6, 0, 25); cfg_write(6, 1, 25); cfg_write(6, 2, 25); cfg_write(6, 3, 25);
        encipher(8, 1'b1, 1'b0, 1'b0, 1'b0, "R7 full wrap four rotors");
        encipher(8, 1'b1, 1'b0, 1'b0, 1'b0, "R7 after full wrap");
        cfg_write(6, 0, 24); cfg_write(6, 1, 3);
        encipher(10, 1'b0, 1'b0, 1'b0, 1'b0, "R7 no carry below wrap");
        encipher(10, 1'b0, 1'b0, 1'b0, 1'b0, "R7 carry on wrap");
        encipher(10, 1'b0, 1'b0, 1'b0, 1'b0, "R7 after carry");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_identity();
        t_load_tables();
        t_four_rotor();
        t_busy_start();
        t_bad_letter();
        t_cfg_rules();
        t_carry();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule